// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a bank of small memory-mapped control registers for a workstation I/O companion device. A bus master reaches each register through a per-register select, an access size and an offset. The bank holds seven registers: configuration, diagnostic, modem control, diagnostic LEDs, system control and two auxiliary registers. Some of these registers have side effects when written.

The second auxiliary register keeps a sticky power-fail flag. The flag follows a synchronized power-fail input, but only while the configuration enable bit is set. Software clears the flag by writing a clear bit. When the flag and the enable bit are both set, the block raises an interrupt. Writes to the auxiliary and system-control registers produce single-cycle strobes:

- a terminal-count pulse for a floppy controller;
- a soft power-off request;
- a system reset request.

Block reset clears most registers. The diagnostic and system-control registers keep their contents across reset, so software can read the cause of a reset after it happens.

Top module: `aux_ctl_bank`

## Requirements
- R1: `irq_o` is high exactly when the power-fail flag (bit 5, 0x20, of the second auxiliary register) and the enable bit (bit 3, 0x08, of the configuration register) are both set.
- R2: `pwr_fail_i` passes through a two-flop synchronizer. On each change of the synchronized level, the power-fail flag becomes (level AND the enable bit held before that cycle). The register shows the new value no later than the third clock edge after the input change.
- R3: A write to the second auxiliary register (select 6) takes only data bits 0 and 1. Bit 1 set clears the power-fail flag, and bit 1 always reads back as 0. In all other cases the flag is kept. A synchronized input change in the same cycle decides the flag instead of the write.
- R4: Writing the second auxiliary register stores data bit 0 as the power-off bit. When that bit is 1, `shutdown_o` is high for exactly one cycle.
- R5: Writing the first auxiliary register (select 5) with data bit 1 set produces one single-cycle pulse on `tc_o`. The register stores the written byte with bit 1 forced to 0.
- R6: The system-control register (select 4) takes word accesses. A write at offset 0 with bit 0 set makes the register read 0x02 and pulses `sysrst_o` for one cycle. A write at offset 0 with bit 0 clear changes nothing.
- R7: The LED register (select 3) takes halfword accesses and reads back the 16 bits last written at offset 0.
- R8: The configuration (select 0), diagnostic (select 1) and modem-control (select 2) registers take byte accesses and read back the byte last written.
- R9: Reset clears the configuration, modem-control, LED and both auxiliary registers. Reset leaves the diagnostic and system-control registers unchanged.
- R10: Size codes are 0 for byte, 1 for halfword and 2 for word. An access with the wrong size for its register, or with select 7, raises `err_o` for one cycle, reads 0 and writes nothing.
- R11: Read data appears on `rdata_o` in the cycle after the access, zero-extended. An access of the correct size at a nonzero offset reads 0, writes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 3 | Register select (0 cfg, 1 diag, 2 modem, 3 LED, 4 sysctl, 5 aux1, 6 aux2) |
| size_i | input | 2 | Access size (0 byte, 1 half, 2 word) |
| off_i | input | OFF_W | Byte offset within the register window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the access |
| err_o | output | 1 | One-cycle size or select error flag |
| pwr_fail_i | input | 1 | Asynchronous power-fail indication |
| irq_o | output | 1 | Power-fail interrupt |
| tc_o | output | 1 | Terminal-count pulse |
| shutdown_o | output | 1 | Power-off request strobe |
| sysrst_o | output | 1 | System reset request strobe |

## Verification
The embedded properties assume the following about the inputs:
- `pwr_fail_i` holds each level for at least two clocks, so the synchronizer sees every change.
- Each access occupies a single cycle with `req_i` high.

The stimulus follows both assumptions:
- Every access is separated by an idle cycle.
- The power-fail input is toggled only between accesses, and then left quiet for four cycles.

Because of this, a bus write and a synchronized input change never meet in the same cycle. The bench can therefore predict the flag from the enable bit held at toggle time.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;
  localparam int NREG = 7;

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_DIAG = 3'd1,
    REG_MDM  = 3'd2,
    REG_LED  = 3'd3,
    REG_SYS  = 3'd4,
    REG_AUX1 = 3'd5,
    REG_AUX2 = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int CFG_PF_EN_BIT = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_RST_BIT   = 0;
  localparam logic [7:0] SYS_STAT_VAL = 8'h02;

  function automatic logic [1:0] need_size(input logic [2:0] sel);
    case (sel)
      REG_LED: need_size = SZ_HALF;
      REG_SYS: need_size = SZ_WORD;
      default: need_size = SZ_BYTE;
    endcase
  endfunction
endpackage

// File: rtl/aux_pf_sync.sv
module aux_pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic change_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o  = chain_q[STAGES-1];
  assign change_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/aux_acc_dec.sv
module aux_acc_dec
  import aux_ctl_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [NREG-1:0]  wr_o,
  output logic             rd_ok_o,
  output logic             err_o
);
  logic sel_ok, size_ok, hit;

  assign sel_ok  = (sel_i < 3'(NREG));
  assign size_ok = sel_ok && (size_i == need_size(sel_i));
  assign err_o   = req_i && !size_ok;
  assign hit     = req_i && size_ok && (off_i == '0);
  assign rd_ok_o = hit && !we_i;

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr_o[g] = hit && we_i && (sel_i == 3'(g));
  end

  always_comb begin
    // R10
    wr_err_excl_chk : assert (!(err_o && (wr_o != '0)));
  end
endmodule

// File: rtl/aux_regfile.sv
module aux_regfile
  import aux_ctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] wr_i,
  input  logic [15:0]     wdata_i,
  input  logic            pf_lvl_i,
  input  logic            pf_chg_i,
  output logic [7:0]      cfg_o,
  output logic [7:0]      diag_o,
  output logic [7:0]      mdm_o,
  output logic [15:0]     led_o,
  output logic [7:0]      sys_o,
  output logic [7:0]      aux1_o,
  output logic [7:0]      aux2_o,
  output logic            irq_o,
  output logic            tc_o,
  output logic            shut_o,
  output logic            sysrst_o
);
  logic [7:0]  cfg_q, diag_q, mdm_q, sys_q, aux1_q;
  logic [15:0] led_q;
  logic        pf_q, off_q, tc_q, shut_q, sysrst_q;
  logic        clr_wr;

  assign clr_wr = wr_i[REG_AUX2] && wdata_i[AUX2_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      mdm_q    <= '0;
      led_q    <= '0;
      aux1_q   <= '0;
      pf_q     <= 1'b0;
      off_q    <= 1'b0;
      tc_q     <= 1'b0;
      shut_q   <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      if (wr_i[REG_CFG]) cfg_q <= wdata_i[7:0];
      if (wr_i[REG_MDM]) mdm_q <= wdata_i[7:0];
      if (wr_i[REG_LED]) led_q <= wdata_i;
      if (wr_i[REG_AUX1]) begin
        aux1_q              <= wdata_i[7:0];
        aux1_q[AUX1_TC_BIT] <= 1'b0;
      end
      tc_q <= wr_i[REG_AUX1] && wdata_i[AUX1_TC_BIT];
      if (wr_i[REG_AUX2]) off_q <= wdata_i[AUX2_OFF_BIT];
      shut_q <= wr_i[REG_AUX2] && wdata_i[AUX2_OFF_BIT];
      // input change outranks the clear write
      if (pf_chg_i)    pf_q <= pf_lvl_i && cfg_q[CFG_PF_EN_BIT];
      else if (clr_wr) pf_q <= 1'b0;
      sysrst_q <= wr_i[REG_SYS] && wdata_i[SYS_RST_BIT];
    end
  end

  // survive block reset
  always_ff @(posedge clk_i) begin
    if (wr_i[REG_DIAG]) diag_q <= wdata_i[7:0];
    if (wr_i[REG_SYS] && wdata_i[SYS_RST_BIT]) sys_q <= SYS_STAT_VAL;
  end

  assign cfg_o    = cfg_q;
  assign diag_o   = diag_q;
  assign mdm_o    = mdm_q;
  assign led_o    = led_q;
  assign sys_o    = sys_q;
  assign aux1_o   = aux1_q;
  assign aux2_o   = {2'b00, pf_q, 4'b0000, off_q};
  assign irq_o    = pf_q && cfg_q[CFG_PF_EN_BIT];
  assign tc_o     = tc_q;
  assign shut_o   = shut_q;
  assign sysrst_o = sysrst_q;

  // R2
  pf_rise_src_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_q) |-> $past(pf_chg_i && pf_lvl_i && cfg_q[CFG_PF_EN_BIT]));

  // R3
  pf_clear_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_wr && !pf_chg_i) |-> !pf_q);

  // R5
  aux1_tc_bit_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |-> !aux1_q[AUX1_TC_BIT]);
endmodule

// File: rtl/aux_ctl_bank.sv
module aux_ctl_bank
  import aux_ctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int OFF_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_o,
  output logic              shutdown_o,
  output logic              sysrst_o
);
  localparam int PAD8  = DATA_W - 8;
  localparam int PAD16 = DATA_W - 16;

  logic [NREG-1:0]   wr;
  logic              rd_ok, err_d, pf_lvl, pf_chg;
  logic [7:0]        cfg, diag, mdm, sys, aux1, aux2;
  logic [15:0]       led;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              err_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:16];

  aux_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pwr_fail_i), .level_o(pf_lvl), .change_o(pf_chg)
  );

  aux_acc_dec #(.OFF_W(OFF_W)) u_dec (
    .req_i, .we_i, .sel_i, .size_i, .off_i,
    .wr_o(wr), .rd_ok_o(rd_ok), .err_o(err_d)
  );

  aux_regfile u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(wdata_i[15:0]),
    .pf_lvl_i(pf_lvl), .pf_chg_i(pf_chg),
    .cfg_o(cfg), .diag_o(diag), .mdm_o(mdm), .led_o(led), .sys_o(sys),
    .aux1_o(aux1), .aux2_o(aux2), .irq_o,
    .tc_o, .shut_o(shutdown_o), .sysrst_o
  );

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      case (sel_i)
        REG_CFG:  rdata_d = {{PAD8{1'b0}}, cfg};
        REG_DIAG: rdata_d = {{PAD8{1'b0}}, diag};
        REG_MDM:  rdata_d = {{PAD8{1'b0}}, mdm};
        REG_LED:  rdata_d = {{PAD16{1'b0}}, led};
        REG_SYS:  rdata_d = {{PAD8{1'b0}}, sys};
        REG_AUX1: rdata_d = {{PAD8{1'b0}}, aux1};
        REG_AUX2: rdata_d = {{PAD8{1'b0}}, aux2};
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R10
  err_zero_data_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  // R5
  tc_src_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> $past(req_i && we_i && sel_i == REG_AUX1 && size_i == SZ_BYTE &&
                   off_i == '0 && wdata_i[AUX1_TC_BIT]));

  // R4
  shutdown_bit_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> aux2[AUX2_OFF_BIT]);

  // R6
  sysrst_stat_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst_o |-> (sys == SYS_STAT_VAL));
endmodule

// File: tb/aux_ctl_bank_test.sv
`timescale 1ns/1ps
module aux_ctl_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, pwr_fail_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [1:0]  size_i = '0, off_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        err_o, irq_o, tc_o, shutdown_o, sysrst_o;

  always #4 clk_i = ~clk_i;

  aux_ctl_bank uut (.*);

  int total = 0, bad = 0;
  logic [7:0]  m_cfg, m_diag, m_mdm, m_sys, m_aux1;
  logic [15:0] m_led;
  logic        m_pf, m_off, m_pin;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_size(input logic [2:0] sel);
    case (sel)
      3'd3: exp_size = 2'd1;
      3'd4: exp_size = 2'd2;
      default: exp_size = 2'd0;
    endcase
  endfunction

  function automatic string sel_tag(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1, 3'd2: sel_tag = "R8";
      3'd3: sel_tag = "R7";
      3'd4: sel_tag = "R6";
      3'd5: sel_tag = "R5";
      3'd6: sel_tag = "R3";
      default: sel_tag = "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_cfg = 0; m_mdm = 0; m_led = 0; m_aux1 = 0; m_pf = 0; m_off = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    repeat (4) @(negedge clk_i);
    m_pf = m_pin & m_cfg[3];
  endtask

  task automatic xfer(input bit we, input logic [2:0] sel, input logic [1:0] sz,
                      input logic [1:0] off, input logic [31:0] wd, input string note);
    bit v, hit, e_tc, e_sh, e_rs;
    logic [31:0] e_rd;
    string tag;
    tag = {sel_tag(sel), " ", note};
    v = (sel != 3'd7) && (sz == exp_size(sel));
    hit = v && (off == 2'd0);
    e_rd = 0; e_tc = 0; e_sh = 0; e_rs = 0;
    if (hit && !we) begin
      case (sel)
        3'd0: e_rd = {24'd0, m_cfg};
        3'd1: e_rd = {24'd0, m_diag};
        3'd2: e_rd = {24'd0, m_mdm};
        3'd3: e_rd = {16'd0, m_led};
        3'd4: e_rd = {24'd0, m_sys};
        3'd5: e_rd = {24'd0, m_aux1};
        3'd6: e_rd = {26'd0, m_pf, 4'd0, m_off};
        default: e_rd = 0;
      endcase
    end
    if (hit && we) begin
      case (sel)
        3'd0: m_cfg = wd[7:0];
        3'd1: m_diag = wd[7:0];
        3'd2: m_mdm = wd[7:0];
        3'd3: m_led = wd[15:0];
        3'd4: if (wd[0]) begin m_sys = 8'h02; e_rs = 1; end
        3'd5: begin m_aux1 = wd[7:0] & 8'hFD; e_tc = wd[1]; end
        3'd6: begin m_off = wd[0]; e_sh = wd[0]; if (wd[1]) m_pf = 0; end
        default: ;
      endcase
    end
    @(negedge clk_i);
    req_i = 1; we_i = we; sel_i = sel; size_i = sz; off_i = off; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    check(err_o == !v, {tag, " R10 err"}, 32'(err_o), 32'(!v));
    check(rdata_o == e_rd, {tag, " R11 rdata"}, rdata_o, e_rd);
    check(tc_o == e_tc, {tag, " R5 tc"}, 32'(tc_o), 32'(e_tc));
    check(shutdown_o == e_sh, {tag, " R4 shutdown"}, 32'(shutdown_o), 32'(e_sh));
    check(sysrst_o == e_rs, {tag, " R6 sysrst"}, 32'(sysrst_o), 32'(e_rs));
    check(irq_o == (m_pf & m_cfg[3]), {tag, " R1 irq"}, 32'(irq_o), 32'(m_pf & m_cfg[3]));
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk_i);
    pwr_fail_i = v;
    repeat (4) @(negedge clk_i);
    if (v != m_pin) m_pf = v & m_cfg[3];
    m_pin = v;
    check(irq_o == (m_pf & m_cfg[3]), "R2 R1 irq after input change", 32'(irq_o), 32'(m_pf & m_cfg[3]));
    xfer(0, 3'd6, 2'd0, 2'd0, 0, "R2 flag after input change");
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pin = 0; m_diag = 0; m_sys = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R9 reset state
    check(irq_o == 0 && tc_o == 0 && shutdown_o == 0 && sysrst_o == 0 && err_o == 0,
          "R9 outputs after reset", {27'd0, irq_o, tc_o, shutdown_o, sysrst_o, err_o}, 0);
    xfer(0, 3'd0, 2'd0, 2'd0, 0, "R9 cfg reset");
    xfer(0, 3'd2, 2'd0, 2'd0, 0, "R9 modem reset");
    xfer(0, 3'd3, 2'd1, 2'd0, 0, "R9 led reset");
    xfer(0, 3'd5, 2'd0, 2'd0, 0, "R9 aux1 reset");
    xfer(0, 3'd6, 2'd0, 2'd0, 0, "R9 aux2 reset");
    // spared registers
    xfer(1, 3'd1, 2'd0, 2'd0, 32'h5A, "R8 diag write");
    xfer(1, 3'd4, 2'd2, 2'd0, 32'h1, "R6 reset request");
    xfer(1, 3'd0, 2'd0, 2'd0, 32'hF7, "R8 cfg write");
    xfer(1, 3'd2, 2'd0, 2'd0, 32'h33, "R8 modem write");
    xfer(1, 3'd3, 2'd1, 2'd0, 32'hBEEF, "R7 led write");
    do_reset();
    xfer(0, 3'd1, 2'd0, 2'd0, 0, "R9 diag kept");
    xfer(0, 3'd4, 2'd2, 2'd0, 0, "R9 sysctl kept");
    xfer(0, 3'd0, 2'd0, 2'd0, 0, "R9 cfg cleared");
    xfer(0, 3'd2, 2'd0, 2'd0, 0, "R9 modem cleared");
    xfer(0, 3'd3, 2'd1, 2'd0, 0, "R9 led cleared");
    // sysctl corners
    xfer(1, 3'd4, 2'd2, 2'd0, 32'hFFFF_FFFE, "R6 bit0 clear no effect");
    xfer(0, 3'd4, 2'd2, 2'd0, 0, "R6 status held");
    xfer(1, 3'd4, 2'd2, 2'd1, 32'h1, "R11 sysctl other offset ignored");
    xfer(0, 3'd4, 2'd2, 2'd2, 0, "R11 sysctl other offset reads 0");
    // power fail
    xfer(1, 3'd0, 2'd0, 2'd0, 32'h08, "R1 enable");
    set_pf(1);
    xfer(1, 3'd0, 2'd0, 2'd0, 32'h00, "R1 enable off masks irq");
    xfer(1, 3'd0, 2'd0, 2'd0, 32'h08, "R1 enable back on");
    xfer(1, 3'd6, 2'd0, 2'd0, 32'h02, "R3 interrupt clear");
    xfer(0, 3'd6, 2'd0, 2'd0, 0, "R3 clear bit not stored");
    xfer(1, 3'd6, 2'd0, 2'd0, 32'hFF, "R4 power off");
    xfer(0, 3'd6, 2'd0, 2'd0, 0, "R3 R4 only low bits kept");
    xfer(1, 3'd6, 2'd0, 2'd0, 32'h00, "R4 power off cleared");
    set_pf(0);
    set_pf(1);
    xfer(1, 3'd6, 2'd0, 2'd0, 32'h01, "R3 flag kept without clear");
    xfer(1, 3'd0, 2'd0, 2'd0, 32'h00, "R2 disable");
    set_pf(0);
    set_pf(1);
    set_pf(0);
    // aux1
    xfer(1, 3'd5, 2'd0, 2'd0, 32'hFF, "R5 tc pulse");
    xfer(0, 3'd5, 2'd0, 2'd0, 0, "R5 tc bit dropped");
    xfer(1, 3'd5, 2'd0, 2'd0, 32'h01, "R5 no tc");
    xfer(0, 3'd5, 2'd0, 2'd0, 0, "R5 readback");
    // size errors
    xfer(1, 3'd3, 2'd1, 2'd0, 32'h1234_BEEF, "R7 halfword write");
    xfer(1, 3'd3, 2'd0, 2'd0, 32'h0000_0000, "R10 led byte write");
    xfer(0, 3'd3, 2'd1, 2'd0, 0, "R10 led unchanged");
    xfer(1, 3'd0, 2'd2, 2'd0, 32'hFF, "R10 cfg word write");
    xfer(0, 3'd0, 2'd0, 2'd0, 0, "R10 cfg unchanged");
    xfer(1, 3'd5, 2'd1, 2'd0, 32'h02, "R10 aux1 half no tc");
    xfer(0, 3'd7, 2'd0, 2'd0, 0, "R10 bad select");
    xfer(0, 3'd4, 2'd0, 2'd0, 0, "R10 sysctl byte read");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [2:0]  s;
      logic [1:0]  z, o;
      logic [31:0] d;
      s = 3'($urandom % 8);
      z = ($urandom % 4 != 0) ? exp_size(s) : 2'($urandom % 4);
      o = ($urandom % 6 == 0) ? 2'($urandom % 4) : 2'd0;
      d = $urandom;
      if (s == 3'd4 && ($urandom % 4 != 0)) d[0] = 1'b0;
      xfer($urandom % 2 == 1, s, z, o, d, "random");
      if ($urandom % 16 == 0) set_pf(~m_pin);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule